// File: doc/BRIEF.md
# Cascaded voltage/current loop controller for a single-phase inverter

The block computes one modulation value per control sample for a full-bridge inverter. A start strobe captures a sampled output voltage and a sampled inductor current. The block then compares the voltage sample with a sine reference taken from an internal table. A proportional-integral stage turns the voltage error into an inductor current demand. A proportional-only stage turns the current error into the compare value for the downstream carrier comparator. The result appears on `mod_out` together with a single-cycle `done` strobe.

All values are signed 16-bit fractions. Gains are signed numbers with 12 fractional bits, so that any feedback scale factor can be folded into them. Three gain registers can be rewritten at run time. The table steps once per finished sample, so at a 50 µs sample period the 400 default entries span one 50 Hz cycle. Sampling, filtering and gain design stay outside the block.

Top module: `vi_cascade_ctrl`

## Requirements
- R1: The reference for a sample is table entry k, where k starts at 0 after reset and advances by one when each result is delivered, wrapping from N-1 (399) back to 0. Entry k, with H = N/2, p = k mod H and integer division truncating toward zero, is AMP·16·p·(H−p) / (5·H² − 4·p·(H−p)). The entry is negated when k ≥ H. AMP defaults to 16384.
- R2: The voltage error is ref − v_smp, clamped to ±32767. The candidate integrator is the stored integrator plus (Ki_v·error >>> 12), clamped to ±32767. The current demand is (Kp_v·error >>> 12) plus the candidate integrator, clamped to ±32767. Here >>> is an arithmetic (floor) shift.
- R3: The current error is the demand minus i_smp, clamped to ±32767. The raw output is Kp_i·current error >>> 12. mod_out is the raw output clamped to ±MOD_LIM (30000 by default).
- R4: The candidate integrator becomes the stored integrator only when the raw output of the same sample lies inside ±MOD_LIM. Otherwise the stored integrator keeps its old value.
- R5: A start seen at rising edge k makes done high for exactly one cycle, following edge k+5. mod_out changes at that same edge and holds its value until the next done.
- R6: A start that arrives while a sample is being processed is ignored. It produces no result and does not advance the table.
- R7: When gain_we is high at a rising edge, gain_val is written to Kp_v if gain_sel = 0, to Ki_v if gain_sel = 1, and to Kp_i if gain_sel = 2. gain_sel = 3 writes nothing. A write affects every sample started after it.
- R8: A synchronous reset clears the integrator, the table index, mod_out and done, and reloads the gains with their defaults (Kp_v = 8192, Ki_v = 410, Kp_i = 12288).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures the samples and begins one computation |
| v_smp | input | 16 | Sampled output voltage, signed fraction |
| i_smp | input | 16 | Sampled inductor current, signed fraction |
| gain_we | input | 1 | Gain register write enable |
| gain_sel | input | 2 | Gain register select (0 Kp_v, 1 Ki_v, 2 Kp_i) |
| gain_val | input | 16 | Signed gain with 12 fractional bits |
| mod_out | output | 16 | Signed compare value for the carrier comparator |
| done | output | 1 | One-cycle strobe marking a new mod_out |

## Verification
The table wrap and the integrator freeze are both settled at the same clock edge. That edge delivers the result, so one sample can return the index to 0 and also throw away its integrator update. The bench provokes this by driving a long run of samples with high current gain and large alternating voltage samples, so that clamped outputs fall on and around the sample taken at entry 399. A reference model computes every result independently, including the entry reached after the wrap and the integrator value held through the clamped samples. Each result is compared with the model as it emerges, so an index that restarts one step off or an integrator that moves during saturation shows up in the next outputs.

// File: rtl/vi_cascade_pkg.sv
package vi_cascade_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_VERR,
      ST_PI,
      ST_IERR,
      ST_P,
      ST_SAT,
      ST_DONE
   } vc_state_e;

   localparam logic [1:0] SEL_KPV = 2'd0;
   localparam logic [1:0] SEL_KIV = 2'd1;
   localparam logic [1:0] SEL_KPI = 2'd2;
endpackage

// File: rtl/vi_clamp.sv
module vi_clamp #(
   parameter int IW  = 33,
   parameter int OW  = 16,
   parameter int LIM = 32767
) (
   input  logic signed [IW-1:0] x,
   output logic signed [OW-1:0] y,
   output logic                 hit
);
   localparam logic signed [IW-1:0] HI = IW'(LIM);
   localparam logic signed [IW-1:0] LO = -HI;

   if (IW <= OW) begin : g_bad_w
      $error("vi_clamp: input must be wider than output");
   end
   if (LIM >= 2**(OW-1)) begin : g_bad_lim
      $error("vi_clamp: limit does not fit the output");
   end

   always_comb begin
      hit = 1'b1;
      if (x > HI)      y = OW'(HI);
      else if (x < LO) y = OW'(LO);
      else begin
         y   = OW'(x);
         hit = 1'b0;
      end
   end
endmodule

// File: rtl/vi_sine_rom.sv
module vi_sine_rom #(
   parameter int N        = 400,
   parameter int W        = 16,
   parameter int AMP      = 16384,
   parameter bit HALF_SYM = 1'b1,
   parameter int IDXW     = $clog2(N)
) (
   input  logic [IDXW-1:0]     idx,
   output logic signed [W-1:0] q
);
   localparam int H  = N / 2;
   localparam int HW = (H > 1) ? $clog2(H) : 1;

   if (N % 2 != 0) begin : g_bad_n
      $error("vi_sine_rom: N must be even");
   end
   if (AMP >= 2**(W-1)) begin : g_bad_amp
      $error("vi_sine_rom: amplitude exceeds word range");
   end

   function automatic longint sine_at(input longint k);
      longint p, num, den, val;
      bit     neg;
      neg = (k >= H);
      p   = neg ? k - H : k;
      num = 16 * p * (H - p);
      den = 5 * longint'(H) * H - 4 * p * (H - p);
      val = (longint'(AMP) * num) / den;
      return neg ? -val : val;
   endfunction

   if (HALF_SYM) begin : g_half
      logic signed [W-1:0] tbl [H];
      for (genvar g = 0; g < H; g++) begin : g_ent
         assign tbl[g] = W'(sine_at(g));
      end
      always_comb begin
         if (idx < IDXW'(H)) q = tbl[HW'(idx)];
         else                q = -tbl[HW'(idx - IDXW'(H))];
      end
   end else begin : g_full
      logic signed [W-1:0] tbl [N];
      for (genvar g = 0; g < N; g++) begin : g_ent
         assign tbl[g] = W'(sine_at(g));
      end
      assign q = tbl[idx];
   end
endmodule

// File: rtl/vi_pi_core.sv
module vi_pi_core #(
   parameter int W  = 16,
   parameter int GW = 16,
   parameter int GF = 12
) (
   input  logic signed [W-1:0]  err,
   input  logic signed [GW-1:0] kp,
   input  logic signed [GW-1:0] ki,
   input  logic signed [W-1:0]  integ,
   output logic signed [W-1:0]  cmd,
   output logic signed [W-1:0]  integ_nxt
);
   localparam int PW  = W + GW;
   localparam int LIM = 2**(W-1) - 1;

   logic signed [PW-1:0] p_term, i_term;
   logic signed [PW:0]   i_sum, c_sum;
   logic                 i_hit, c_hit;

   assign p_term = (kp * err) >>> GF;
   assign i_term = (ki * err) >>> GF;
   assign i_sum  = (PW+1)'(i_term) + (PW+1)'(integ);
   assign c_sum  = (PW+1)'(p_term) + (PW+1)'(integ_nxt);

   vi_clamp #(.IW(PW+1), .OW(W), .LIM(LIM)) u_int_clamp (
      .x(i_sum), .y(integ_nxt), .hit(i_hit));
   vi_clamp #(.IW(PW+1), .OW(W), .LIM(LIM)) u_cmd_clamp (
      .x(c_sum), .y(cmd), .hit(c_hit));

   logic unused_hits;
   assign unused_hits = i_hit ^ c_hit;
endmodule

// File: rtl/vi_cascade_ctrl.sv
module vi_cascade_ctrl #(
   parameter int W        = 16,
   parameter int GW       = 16,
   parameter int GF       = 12,
   parameter int N        = 400,
   parameter int SIN_AMP  = 16384,
   parameter int MOD_LIM  = 30000,
   parameter bit HALF_SYM = 1'b1,
   parameter int KPV0     = 8192,
   parameter int KIV0     = 410,
   parameter int KPI0     = 12288
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic signed [W-1:0]  v_smp,
   input  logic signed [W-1:0]  i_smp,
   input  logic                 gain_we,
   input  logic [1:0]           gain_sel,
   input  logic signed [GW-1:0] gain_val,
   output logic signed [W-1:0]  mod_out,
   output logic                 done
);
   import vi_cascade_pkg::*;

   localparam int IDXW = $clog2(N);
   localparam int PW   = W + GW;
   localparam int LIM  = 2**(W-1) - 1;

   if (GF >= GW) begin : g_bad_gf
      $error("vi_cascade_ctrl: fraction bits must be below gain width");
   end
   if (MOD_LIM > LIM || MOD_LIM <= 0) begin : g_bad_mod
      $error("vi_cascade_ctrl: MOD_LIM out of range");
   end
   if (N < 4) begin : g_bad_n
      $error("vi_cascade_ctrl: table too short");
   end

   vc_state_e             st;
   logic [IDXW-1:0]       idx_q;
   logic signed [W-1:0]   v_q, i_q, ref_q, ev_q, icmd_q, inx_q, ei_q, integ_q;
   logic signed [PW-1:0]  mraw_q;
   logic signed [GW-1:0]  kpv_q, kiv_q, kpi_q;

   logic signed [W-1:0]   rom_q, ev_c, cmd_c, inx_c, ei_c, mod_c;
   logic signed [PW-1:0]  mraw_c;
   logic                  ev_hit, ei_hit, mod_hit;

   vi_sine_rom #(.N(N), .W(W), .AMP(SIN_AMP), .HALF_SYM(HALF_SYM), .IDXW(IDXW)) u_rom (
      .idx(idx_q), .q(rom_q));

   vi_clamp #(.IW(W+1), .OW(W), .LIM(LIM)) u_ev_clamp (
      .x((W+1)'(ref_q) - (W+1)'(v_q)), .y(ev_c), .hit(ev_hit));

   vi_pi_core #(.W(W), .GW(GW), .GF(GF)) u_pi (
      .err(ev_q), .kp(kpv_q), .ki(kiv_q), .integ(integ_q),
      .cmd(cmd_c), .integ_nxt(inx_c));

   vi_clamp #(.IW(W+1), .OW(W), .LIM(LIM)) u_ei_clamp (
      .x((W+1)'(icmd_q) - (W+1)'(i_q)), .y(ei_c), .hit(ei_hit));

   assign mraw_c = (kpi_q * ei_q) >>> GF;

   vi_clamp #(.IW(PW), .OW(W), .LIM(MOD_LIM)) u_mod_clamp (
      .x(mraw_q), .y(mod_c), .hit(mod_hit));

   logic unused_hits;
   assign unused_hits = ev_hit ^ ei_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         idx_q   <= '0;
         integ_q <= '0;
         mod_out <= '0;
         done    <= 1'b0;
         v_q     <= '0;
         i_q     <= '0;
         ref_q   <= '0;
         ev_q    <= '0;
         icmd_q  <= '0;
         inx_q   <= '0;
         ei_q    <= '0;
         mraw_q  <= '0;
         kpv_q   <= GW'(KPV0);
         kiv_q   <= GW'(KIV0);
         kpi_q   <= GW'(KPI0);
      end else begin
         done <= 1'b0;
         if (gain_we) begin
            case (gain_sel)
               SEL_KPV: kpv_q <= gain_val;
               SEL_KIV: kiv_q <= gain_val;
               SEL_KPI: kpi_q <= gain_val;
               default: ;
            endcase
         end
         case (st)
            ST_IDLE: if (start) begin
               v_q   <= v_smp;
               i_q   <= i_smp;
               ref_q <= rom_q;
               st    <= ST_VERR;
            end
            ST_VERR: begin
               ev_q <= ev_c;
               st   <= ST_PI;
            end
            ST_PI: begin
               icmd_q <= cmd_c;
               inx_q  <= inx_c;
               st     <= ST_IERR;
            end
            ST_IERR: begin
               ei_q <= ei_c;
               st   <= ST_P;
            end
            ST_P: begin
               mraw_q <= mraw_c;
               st     <= ST_SAT;
            end
            ST_SAT: begin
               mod_out <= mod_c;
               if (!mod_hit) integ_q <= inx_q;
               idx_q <= (idx_q == IDXW'(N-1)) ? '0 : idx_q + 1'b1;
               done  <= 1'b1;
               st    <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vi_cascade_chk.sv
module vi_cascade_chk #(
   parameter int W       = 16,
   parameter int N       = 400,
   parameter int MOD_LIM = 30000,
   parameter int IDXW    = $clog2(N)
) (
   input logic                clk,
   input logic                rst,
   input logic                done,
   input logic signed [W-1:0] mod,
   input logic signed [W-1:0] integ,
   input logic [IDXW-1:0]     idx
);
   localparam logic signed [W-1:0] MHI = W'(MOD_LIM);

   assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_mod_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !$stable(mod) |-> done);

   assert_mod_range_R3: assert property (@(posedge clk) disable iff (rst)
      (mod <= MHI) && (mod >= -MHI));

   assert_integ_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(integ) |-> done);

   assert_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
      idx < IDXW'(N));

   assert_idx_step_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> idx == (($past(idx) == IDXW'(N-1)) ? '0 : $past(idx) + 1'b1));
endmodule

bind vi_cascade_ctrl vi_cascade_chk #(.W(W), .N(N), .MOD_LIM(MOD_LIM), .IDXW(IDXW)) u_chk (
   .clk(clk), .rst(rst), .done(done), .mod(mod_out), .integ(integ_q), .idx(idx_q));

// File: tb/sim_vi_cascade_ctrl.sv
module sim_vi_cascade_ctrl;
   localparam int     N    = 400;
   localparam int     GF   = 12;
   localparam longint AMP  = 16384;
   localparam longint MLIM = 30000;
   localparam longint LIM  = 32767;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic signed [15:0] v_smp = '0, i_smp = '0, gain_val = '0;
   logic gain_we = 1'b0;
   logic [1:0] gain_sel = '0;
   logic signed [15:0] mod_out;
   logic done;

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   longint exp_q[$];
   longint m_integ, m_idx, m_kpv, m_kiv, m_kpi;

   always #10 clk = ~clk;

   vi_cascade_ctrl u0 (
      .clk(clk), .rst(rst), .start(start), .v_smp(v_smp), .i_smp(i_smp),
      .gain_we(gain_we), .gain_sel(gain_sel), .gain_val(gain_val),
      .mod_out(mod_out), .done(done));

   function automatic longint clampv(input longint x, input longint lim);
      if (x > lim)  return lim;
      if (x < -lim) return -lim;
      return x;
   endfunction

   function automatic longint table_at(input longint k);
      longint h, p, v;
      h = N / 2;
      p = (k >= h) ? k - h : k;
      v = (AMP * 16 * p * (h - p)) / (5 * h * h - 4 * p * (h - p));
      return (k >= h) ? -v : v;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic model_reset();
      m_integ = 0; m_idx = 0;
      m_kpv = 8192; m_kiv = 410; m_kpi = 12288;
   endtask

   // Reference model of R1..R4, one expected mod_out per sample
   task automatic predict(input longint v, input longint i);
      longint ev, inx, cmd, ei, mr;
      ev  = clampv(table_at(m_idx) - v, LIM);
      inx = clampv(m_integ + ((m_kiv * ev) >>> GF), LIM);
      cmd = clampv(((m_kpv * ev) >>> GF) + inx, LIM);
      ei  = clampv(cmd - i, LIM);
      mr  = (m_kpi * ei) >>> GF;
      if (mr <= MLIM && mr >= -MLIM) m_integ = inx;   // R4 freeze otherwise
      m_idx = (m_idx + 1) % N;
      exp_q.push_back(clampv(mr, MLIM));
   endtask

   // Scoreboard monitor: R2/R3/R4 values, R6 no stray results
   always @(negedge clk) begin
      if (!rst && done) begin
         if (exp_q.size() == 0) check(1'b0, "R6 unexpected done", 1, 0);
         else begin
            longint e;
            e = exp_q.pop_front();
            check(longint'(mod_out) == e, "R2/R3 mod_out", longint'(mod_out), e);
         end
      end
   end

   task automatic run_sample(input longint v, input longint i, input bit poke_busy);
      int cyc;
      predict(v, i);
      @(negedge clk);
      v_smp = 16'(v); i_smp = 16'(i); start = 1'b1;
      cyc = 0;
      while (1) begin
         @(negedge clk);
         cyc++;
         start = (poke_busy && (cyc == 1 || cyc == 3)) ? 1'b1 : 1'b0;
         if (done || cyc > 20) break;
      end
      start = 1'b0;
      if (poke_busy) check(cyc == 6, "R5 done latency", cyc, 6);
      @(negedge clk);
      check(done == 1'b0, "R5 done one cycle", done, 0);
   endtask

   task automatic write_gain(input logic [1:0] sel, input longint val);
      @(negedge clk);
      gain_we = 1'b1; gain_sel = sel; gain_val = 16'(val);
      @(negedge clk);
      gain_we = 1'b0;
      if (sel == 2'd0) m_kpv = val;
      else if (sel == 2'd1) m_kiv = val;
      else if (sel == 2'd2) m_kpi = val;   // R7: select 3 is ignored
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
      check(mod_out == 16'sd0, "R8 mod_out after reset", mod_out, 0);
      check(done == 1'b0, "R8 done after reset", done, 0);
   endtask

   initial begin
      #4_000_000;
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();
      // R5/R6: latency and busy starts ignored
      run_sample(1000, 200, 1'b1);
      run_sample(-500, -100, 1'b1);
      // R2/R3: assorted patterns with default gains
      run_sample(0, 0, 1'b0);
      run_sample(12000, -4000, 1'b0);
      run_sample(-9000, 7000, 1'b0);
      // R7: gain loads, select 3 ignored
      write_gain(2'd0, 4096);
      write_gain(2'd1, 2048);
      write_gain(2'd2, 20000);
      write_gain(2'd3, 1);
      run_sample(3000, 1500, 1'b0);
      run_sample(-3000, 0, 1'b0);
      write_gain(2'd3, -32768);
      run_sample(500, 500, 1'b0);
      // R4: drive into saturation, then recover
      write_gain(2'd2, 32767);
      for (int k = 0; k < 6; k++) run_sample(-25000, 0, 1'b0);
      for (int k = 0; k < 4; k++) run_sample(0, 0, 1'b0);
      // R1/R4: long run crossing the wrap with frequent clamped outputs
      for (int k = 0; k < 420; k++)
         run_sample(((k % 7) < 3) ? 24000 : -3000, (k % 5) * 700 - 1400, 1'b0);
      // R8: reset mid-run restores index, integrator and gains
      do_reset();
      run_sample(100, -50, 1'b1);
      run_sample(-20000, 9000, 1'b0);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R6 results outstanding", exp_q.size(), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule